// File: doc/BRIEF.md
# Dual-Port Burst-of-Two SRAM Model

This block is a synthesizable memory model with an independent read port and write port. Every access moves a pair of data words that share one address, so each array entry holds a storage word twice the data width. Requests on both ports are taken on the same input clock. Double-data-rate pin timing is represented by a core clock running at twice the data rate together with a beat phase: a "rise" half and a "fall" half alternate on successive clock edges, and the phase is brought out on `beat_hi`.

A read request is sampled on a rise edge, and two edges later the port presents the lower word of the pair, then the upper word, then releases the bus. A write request is sampled on a rise edge together with its first data beat. The second beat and the write address follow on the fall edge, and the pair is committed to the array on the next rise edge. Each data beat carries its own active-low enable per byte lane. Reads that overlap an uncommitted write receive the enabled lanes of that write through forwarding.

Top module: `ram_b2_dp`

## Requirements
- R1: While `rst_n` is low and after reset, `rd_valid` and `rd_oe` are 0, `rd_data` is 0, `beat_hi` is 0, and every array entry reads back as 0.
- R2: A read request (`rd_sel_n` low on a clock edge where `beat_hi` is 0) puts its first word on `rd_data` with `rd_valid` high right after the second following clock edge.
- R3: A read burst presents the lower half (bits W-1:0, the word written on the rise beat) first and the upper half (the word written on the fall beat) on the next edge.
- R4: After the upper word, `rd_valid` and `rd_oe` drop to 0 and `rd_data` to 0 on the next edge unless another burst follows. Reads requested on consecutive rise edges give a gapless output stream.
- R5: A write request (`wr_sel_n` low on an edge where `beat_hi` is 0) captures `wr_data` and `wr_be_n` as the lower word of the pair on that edge.
- R6: On the following edge (`beat_hi` 1), the write takes `wr_data` and `wr_be_n` as the upper word and `wr_addr` as its address. The pair is committed to the array on the next edge.
- R7: `wr_be_n[i]` low enables byte lane i (bits i*LANE_W up to i*LANE_W+LANE_W-1) of the current beat. A lane whose enable is high keeps its stored value.
- R8: A read and a write may start on the same edge, to the same or different addresses, and neither disturbs the other.
- R9: A read returns the array content including every write whose request edge is at or before the read's request edge, even when that write is still uncommitted. The merge is per byte lane.
- R10: `rd_sel_n`, `rd_addr` and `wr_sel_n` are ignored on edges where `beat_hi` is 1.
- R11: With `wr_sel_n` high on a rise edge, the write data, enables and address have no effect. A write already in progress still completes its second beat.
- R12: `beat_hi` toggles on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at twice the data rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read request, active low, sampled on rise edges |
| rd_addr | input | ADDR_W | Read address, captured with the request |
| wr_sel_n | input | 1 | Write request, active low, sampled on rise edges |
| wr_addr | input | ADDR_W | Write address, captured on the fall edge |
| wr_data | input | LANES*LANE_W | Write data beat |
| wr_be_n | input | LANES | Per-lane write enable for the current beat, active low |
| beat_hi | output | 1 | Beat phase: 1 means the next edge is a fall edge |
| rd_data | output | LANES*LANE_W | Read data beat, zero while not driven |
| rd_valid | output | 1 | Read data beat valid |
| rd_oe | output | 1 | Output drive enable for the read bus |

## Verification
A corrupted array entry or a lost lane enable shows up as a wrong `rd_data` word on the first read of that address. That read reaches the port two edges after the request. A forwarding or commit-timing fault shows only when a read overlaps a write to the same address within one rise edge, so the stimulus mixes directed collisions with random traffic over four addresses. A wrong beat phase or a stuck read pipeline shows within one or two edges as a misplaced `rd_valid`, a swapped word order, or a bus that is not released.

// File: rtl/ram_b2_pkg.sv
package ram_b2_pkg;
    // beat phase of the double-rate core clock
    typedef enum logic {
        BEAT_RISE = 1'b0,
        BEAT_FALL = 1'b1
    } beat_e;
endpackage

// File: rtl/ram_b2_wr.sv
module ram_b2_wr #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rise,
    input  logic                          wr_sel_n,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [LANES*LANE_W-1:0]       wr_data,
    input  logic [LANES-1:0]              wr_be_n,
    output logic                          pend_valid,
    output logic [ADDR_W-1:0]             pend_addr,
    output logic [2*LANES*LANE_W-1:0]     pend_data,
    output logic [2*LANES-1:0]            pend_mask
);
    localparam int W = LANES * LANE_W;

    typedef struct packed {
        logic                act;
        logic [W-1:0]        d0;
        logic [LANES-1:0]    m0;
        logic                pv;
        logic [ADDR_W-1:0]   pa;
        logic [2*W-1:0]      pd;
        logic [2*LANES-1:0]  pm;
    } wr_st_t;

    wr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rise) begin
            // pending pair is committed on this edge
            s_d.pv  = 1'b0;
            s_d.act = ~wr_sel_n;
            if (!wr_sel_n) begin
                s_d.d0 = wr_data;
                s_d.m0 = ~wr_be_n;
            end
        end else if (s_q.act) begin
            // second beat and address, taken regardless of the select
            s_d.act = 1'b0;
            s_d.pv  = 1'b1;
            s_d.pa  = wr_addr;
            s_d.pd  = {wr_data, s_q.d0};
            s_d.pm  = {~wr_be_n, s_q.m0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_valid = s_q.pv;
    assign pend_addr  = s_q.pa;
    assign pend_data  = s_q.pd;
    assign pend_mask  = s_q.pm;
endmodule

// File: rtl/ram_b2_array.sv
module ram_b2_array #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ADDR_W-1:0]             cm_addr,
    input  logic [2*LANES*LANE_W-1:0]     cm_data,
    input  logic [2*LANES-1:0]            cm_mask,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [2*LANES*LANE_W-1:0]     rd_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SW    = 2 * LANES * LANE_W;
    localparam int SL    = 2 * LANES;

    typedef struct packed {
        logic [DEPTH-1:0][SW-1:0] mem;
    } arr_st_t;

    arr_st_t s_d, s_q;
    logic [SW-1:0] bit_mask;

    // expand lane enables to bit enables
    for (genvar g = 0; g < SL; g++) begin : g_lane
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{cm_mask[g]}};
    end

    always_comb begin
        s_d = s_q;
        if (commit) begin
            s_d.mem[cm_addr] = (s_q.mem[cm_addr] & ~bit_mask) | (cm_data & bit_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_word = s_q.mem[rd_addr];
endmodule

// File: rtl/ram_b2_rd.sv
module ram_b2_rd #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rise,
    input  logic                          rd_sel_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [2*LANES*LANE_W-1:0]     arr_word,
    input  logic                          pend_valid,
    input  logic [ADDR_W-1:0]             pend_addr,
    input  logic [2*LANES*LANE_W-1:0]     pend_data,
    input  logic [2*LANES-1:0]            pend_mask,
    output logic [ADDR_W-1:0]             arr_addr,
    output logic [LANES*LANE_W-1:0]       rd_data,
    output logic                          rd_valid,
    output logic                          rd_oe
);
    localparam int W  = LANES * LANE_W;
    localparam int SW = 2 * W;
    localparam int SL = 2 * LANES;

    typedef struct packed {
        logic                rv;
        logic [ADDR_W-1:0]   ra;
        logic                hv;
        logic [W-1:0]        hw;
        logic                v;
        logic                oe;
        logic [W-1:0]        d;
    } rd_st_t;

    rd_st_t s_d, s_q;
    logic          fwd_hit;
    logic [SW-1:0] merged;

    assign fwd_hit = pend_valid && (pend_addr == s_q.ra);

    // lane-wise forwarding of an uncommitted write
    for (genvar g = 0; g < SL; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] = (fwd_hit && pend_mask[g]) ?
            pend_data[g*LANE_W +: LANE_W] : arr_word[g*LANE_W +: LANE_W];
    end

    always_comb begin
        s_d    = s_q;
        s_d.v  = 1'b0;
        s_d.oe = 1'b0;
        s_d.d  = '0;
        if (rise) begin
            s_d.hv = 1'b0;
            if (s_q.rv) begin
                s_d.v  = 1'b1;
                s_d.oe = 1'b1;
                s_d.d  = merged[W-1:0];
                s_d.hw = merged[SW-1:W];
                s_d.hv = 1'b1;
            end
            s_d.rv = ~rd_sel_n;
            s_d.ra = rd_addr;
        end else if (s_q.hv) begin
            s_d.v  = 1'b1;
            s_d.oe = 1'b1;
            s_d.d  = s_q.hw;
            s_d.hv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign arr_addr = s_q.ra;
    assign rd_data  = s_q.d;
    assign rd_valid = s_q.v;
    assign rd_oe    = s_q.oe;
endmodule

// File: rtl/ram_b2_dp.sv
module ram_b2_dp #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_sel_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     wr_sel_n,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [LANES-1:0]         wr_be_n,
    output logic                     beat_hi,
    output logic [LANES*LANE_W-1:0]  rd_data,
    output logic                     rd_valid,
    output logic                     rd_oe
);
    import ram_b2_pkg::*;

    localparam int SW = 2 * LANES * LANE_W;
    localparam int SL = 2 * LANES;

    typedef struct packed {
        beat_e ph;
    } top_st_t;

    top_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ph = (s_q.ph == BEAT_RISE) ? BEAT_FALL : BEAT_RISE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: BEAT_RISE};
        else        s_q <= s_d;
    end

    logic              rise;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [SW-1:0]     pend_data;
    logic [SL-1:0]     pend_mask;
    logic [ADDR_W-1:0] arr_addr;
    logic [SW-1:0]     arr_word;

    assign rise    = (s_q.ph == BEAT_RISE);
    assign beat_hi = (s_q.ph == BEAT_FALL);

    ram_b2_wr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_wr (
        .clk(clk), .rst_n(rst_n), .rise(rise),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
        .pend_valid(pend_valid), .pend_addr(pend_addr),
        .pend_data(pend_data), .pend_mask(pend_mask)
    );

    ram_b2_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_array (
        .clk(clk), .rst_n(rst_n),
        .commit(pend_valid && rise), .cm_addr(pend_addr),
        .cm_data(pend_data), .cm_mask(pend_mask),
        .rd_addr(arr_addr), .rd_word(arr_word)
    );

    ram_b2_rd #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_rd (
        .clk(clk), .rst_n(rst_n), .rise(rise),
        .rd_sel_n(rd_sel_n), .rd_addr(rd_addr), .arr_word(arr_word),
        .pend_valid(pend_valid), .pend_addr(pend_addr),
        .pend_data(pend_data), .pend_mask(pend_mask),
        .arr_addr(arr_addr), .rd_data(rd_data), .rd_valid(rd_valid), .rd_oe(rd_oe)
    );
endmodule

// File: rtl/ram_b2_chk.sv
module ram_b2_chk (
    input logic clk,
    input logic rst_n,
    input logic beat_hi,
    input logic rd_sel_n,
    input logic wr_sel_n,
    input logic rd_valid,
    input logic pend_valid
);
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_hi && !rd_sel_n) |=> ##2 (rd_valid && beat_hi)); // R2

    AST_UPPER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && beat_hi) |=> rd_valid); // R3

    AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> beat_hi); // R3

    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> beat_hi); // R4

    AST_WR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_hi && !wr_sel_n) |=> ##1 pend_valid); // R6

    AST_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> !pend_valid); // R6

    AST_PEND_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> !beat_hi); // R6
endmodule

bind ram_b2_dp ram_b2_chk i_chk (
    .clk(clk), .rst_n(rst_n), .beat_hi(beat_hi),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .rd_valid(rd_valid), .pend_valid(pend_valid)
);

// File: tb/test_ram_b2_dp.sv
module test_ram_b2_dp;
    localparam int AW = 4, LW = 9, NL = 2;
    localparam int W = LW * NL, SW = 2 * W, DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [NL-1:0] wr_be_n = '1;
    logic beat_hi, rd_valid, rd_oe;
    logic [W-1:0] rd_data;

    ram_b2_dp #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) i_ram_b2_dp (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
        .beat_hi(beat_hi), .rd_data(rd_data), .rd_valid(rd_valid), .rd_oe(rd_oe)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [SW-1:0] mmem [DEPTH];
    bit mph, rp_v, hi_v, w_act, ev;
    logic [AW-1:0] rp_a;
    logic [W-1:0] hi_w, w_d0, ed;
    logic [NL-1:0] w_m0;

    function automatic logic [W-1:0] lanes(logic [W-1:0] old, logic [W-1:0] nw, logic [NL-1:0] en);
        logic [W-1:0] r = old;
        for (int i = 0; i < NL; i++) if (en[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; rp_v = 0; hi_v = 0; w_act = 0; ev = 0; ed = '0;
            for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
        end else begin
            ev = 0; ed = '0;
            if (!mph) begin
                if (rp_v) begin
                    ev = 1; ed = mmem[rp_a][W-1:0]; hi_w = mmem[rp_a][SW-1:W]; hi_v = 1;
                end
                rp_v = !rd_sel_n; rp_a = rd_addr;
                w_act = !wr_sel_n;
                if (!wr_sel_n) begin w_d0 = wr_data; w_m0 = ~wr_be_n; end
            end else begin
                if (hi_v) begin ev = 1; ed = hi_w; hi_v = 0; end
                if (w_act) begin
                    mmem[wr_addr] = {lanes(mmem[wr_addr][SW-1:W], wr_data, ~wr_be_n),
                                     lanes(mmem[wr_addr][W-1:0], w_d0, w_m0)};
                    w_act = 0;
                end
            end
            mph = !mph;
        end
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        check(cur_req, W'(rd_valid), W'(ev), "rd_valid");
        check(cur_req, W'(rd_oe), W'(ev), "rd_oe");
        check(cur_req, rd_data, ed, "rd_data");
        check("R12", W'(beat_hi), W'(mph), "beat_hi");
    end

    // one burst slot: rise half then fall half; called at a negedge with mph==0
    task automatic slot(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                        logic [W-1:0] d0, logic [NL-1:0] b0n,
                        logic [W-1:0] d1, logic [NL-1:0] b1n, bit noise);
        while (mph) @(negedge clk);
        rd_sel_n = !rd; rd_addr = ra; wr_sel_n = !wr;
        wr_data = d0; wr_be_n = b0n; wr_addr = AW'($urandom);
        @(negedge clk);
        rd_sel_n = !noise; wr_sel_n = !noise; rd_addr = AW'($urandom);
        wr_addr = wa; wr_data = d1; wr_be_n = b1n;
        @(negedge clk);
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    endtask

    task automatic idle(int n);
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", W'(rd_valid), '0, "rd_valid in reset");
        check("R1", W'(rd_oe), '0, "rd_oe in reset");
        check("R1", rd_data, '0, "rd_data in reset");
        check("R1", W'(beat_hi), '0, "beat_hi in reset");
        rst_n = 1'b1;
        cur_req = "R1";
        slot(1, 4'd9, 0, 0, '0, '1, '0, '1, 0);          // R1: array starts cleared
        idle(4);
        // R5 R6 R3 R2: full write, then read back
        cur_req = "R5";
        slot(0, 0, 1, 4'd1, 18'h1234a, 2'b00, 18'h2bcde, 2'b00, 0);
        idle(2);
        cur_req = "R3";
        slot(1, 4'd1, 0, 0, '0, '1, '0, '1, 0);
        idle(4);
        // R7: per-beat lane enables
        cur_req = "R7";
        slot(0, 0, 1, 4'd1, 18'h3ffff, 2'b01, 18'h15555, 2'b10, 0);
        idle(2);
        slot(1, 4'd1, 0, 0, '0, '1, '0, '1, 0);
        idle(4);
        // R4: back-to-back reads then release
        cur_req = "R4";
        slot(1, 4'd1, 0, 0, '0, '1, '0, '1, 0);
        slot(1, 4'd9, 0, 0, '0, '1, '0, '1, 0);
        slot(1, 4'd1, 0, 0, '0, '1, '0, '1, 0);
        idle(6);
        // R8: concurrent read and write to different addresses
        cur_req = "R8";
        slot(1, 4'd1, 1, 4'd3, 18'h00c3c, 2'b00, 18'h3a5a5, 2'b00, 0);
        slot(1, 4'd3, 0, 0, '0, '1, '0, '1, 0);
        idle(4);
        // R9: forwarding from a write requested on the same edge, partial lanes
        cur_req = "R9";
        slot(1, 4'd5, 1, 4'd5, 18'h11111, 2'b10, 18'h22222, 2'b01, 0);
        slot(1, 4'd5, 1, 4'd5, 18'h3cccc, 2'b00, 18'h0f0f0, 2'b00, 0);
        slot(1, 4'd5, 0, 0, '0, '1, '0, '1, 0);
        idle(4);
        // R10: selects in the fall half are ignored
        cur_req = "R10";
        slot(0, 0, 0, 0, 18'h2aaaa, 2'b00, 18'h15555, 2'b00, 1);
        idle(2);
        slot(1, 4'd1, 0, 0, '0, '1, '0, '1, 1);
        idle(4);
        // R11: deselected write port ignores data, enables and address
        cur_req = "R11";
        slot(0, 0, 0, 4'd6, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00, 0);
        slot(1, 4'd6, 1, 4'd7, 18'h01234, 2'b00, 18'h04321, 2'b00, 0);
        slot(1, 4'd7, 0, 4'd7, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00, 0);
        idle(4);
        // R9 R8: random collisions over a narrow address range
        cur_req = "R9";
        for (int k = 0; k < 400; k++) begin
            slot($urandom_range(0, 1) == 1, AW'($urandom_range(0, 3)),
                 $urandom_range(0, 1) == 1, AW'($urandom_range(0, 3)),
                 W'($urandom), NL'($urandom), W'($urandom), NL'($urandom),
                 $urandom_range(0, 3) == 0);
        end
        idle(6);
        finish_run();
    end
endmodule